// File: doc/BRIEF.md
# Flash Query and Identifier Read Responder

This block forms the read word returned by an interleaved flash bank while the bank is in parameter-query mode or in identifier mode. The bank is one or more identical flash devices placed side by side on a data path of 1, 2 or 4 bytes. Each request carries a byte offset, an access size and a mode bit. The block derives the parameter-table index from the offset and the interleave configuration, reads the table, and copies the per-device answer into every device lane of the bank. For accesses wider than the bank it also fills each bank-wide slice of the word. The geometry entries of the table (device size, erase-block count, sector size and write-buffer size) are computed from configuration inputs. The identifier codes also come from configuration inputs.

The address-to-data path is combinational, and the result is captured in a register, so a response appears one clock after its request. A two-state machine tracks whether the registered word is fresh. State ST_IDLE moves to ST_VALID when a request is present. ST_VALID stays in ST_VALID on a further request and returns to ST_IDLE when there is none. Command decoding and array storage belong to neighbouring blocks.

Top module: `flq_responder`

## Requirements
- R1: A request sampled at a rising edge makes `rsp_valid` high and `rsp_data` hold its answer after that edge. A cycle without a request clears `rsp_valid` and leaves `rsp_data` unchanged. After reset both outputs are zero.
- R2: Every response byte at or above the access size `req_bytes` (1, 2 or 4) reads zero.
- R3: With a nonzero device width, the query index is the full offset shifted right by log2(bank bytes) + log2(max device bytes) − log2(device bytes). A max device width of 0 means it equals the device width. Any index of 0x52 or more answers zero. No truncation to 8 bits is applied before this comparison.
- R4: When the max device width differs from the device width and the device width is 1, the table byte fills every byte of the max device width. When they differ and the device width is not 1, the lane answers zero.
- R5: When the device width is below the bank width, the low device-width bytes of the answer are repeated across every device lane of the bank.
- R6: The response byte lane starting at byte i (a multiple of the bank width) is answered for offset + i × bank bytes.
- R7: With device width 0 (legacy mode), the index is offset bits 7:0 shifted right by log2(bank bytes). A query returns the table byte, or zero for an index of 0x52 or more. In identifier mode (`req_ident`=1), index 0 returns (id0<<8)|id1 and index 1 returns (id2<<8)|id3. Any other index returns zero.
- R8: In identifier mode with a nonzero device width, the index is taken modulo 256. Index 0 yields id0, index 1 yields id1, and any other index yields zero with no lane copying.
- R9: These fixed table entries hold: 0x10–0x13 = 51 52 59 01; 0x15 = 31; 0x1B = 45; 0x1C = 55; 0x1F = 07; 0x20 = 07; 0x21 = 0A; 0x23–0x25 = 04; 0x28 = 02; 0x2C = 01; 0x31–0x35 = 50 52 49 31 30; 0x3F = 01. All other entries below 0x52 that R10 does not name are zero.
- R10: Devices = bank bytes / device bytes (1 in legacy mode). Per-device sector = sector bytes / devices. Entry 0x27 = log2 of per-device sector × block count. Entry 0x2A = 08 for a 1-byte bank and 0B otherwise. Entries 0x2D/0x2E = block count − 1, low then high byte. Entries 0x2F/0x30 = bits 15:8 / 23:16 of the per-device sector.
- R11: `wbuf_bytes` = 2^(entry 0x2A) × devices, and it is always a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present this cycle |
| req_ident | input | 1 | 1 = identifier mode, 0 = query mode |
| req_offset | input | OFF_W | Byte offset of the access |
| req_bytes | input | 3 | Access size in bytes: 1, 2 or 4 |
| cfg_bank_bytes | input | 3 | Bank data width in bytes: 1, 2 or 4 |
| cfg_dev_bytes | input | 3 | Device width in bytes: 0 (legacy), 1, 2 or 4 |
| cfg_maxdev_bytes | input | 3 | Widest mode of a device, 0 = same as device width |
| cfg_id0 | input | ID_W | Manufacturer code |
| cfg_id1 | input | ID_W | Device code |
| cfg_id2 | input | ID_W | Extra code, legacy index 1 high part |
| cfg_id3 | input | ID_W | Extra code, legacy index 1 low part |
| cfg_blocks | input | BLK_W | Erase-block count |
| cfg_sector_bytes | input | SEC_W | Erase-block size of the whole bank in bytes |
| rsp_valid | output | 1 | Registered response is fresh |
| rsp_data | output | 32 | Registered response word |
| wbuf_bytes | output | WB_W | Write-buffer size of the bank in bytes |

## Verification
Two things can fall in the same clock cycle. One is a new request being captured. The other is the previous response being presented. The bench drives requests on consecutive cycles with different offsets and modes. It then checks that each answer appears exactly one cycle after its own request and is not overwritten early. Last, it leaves a gap and checks that the valid flag drops while the last word holds.

// File: rtl/flq_pkg.sv
package flq_pkg;

    localparam int RSP_BYTES = 4;
    localparam int RSP_W     = 8 * RSP_BYTES;
    localparam logic [7:0] TBL_LEN = 8'h52;

    typedef enum logic {
        ST_IDLE,
        ST_VALID
    } flq_state_e;

    typedef struct packed {
        logic [7:0] size_log2;
        logic [7:0] wbuf_log2;
        logic [7:0] blk_lo;
        logic [7:0] blk_hi;
        logic [7:0] sec_mid;
        logic [7:0] sec_hi;
    } flq_geom_t;

    function automatic int lg_bytes(input logic [2:0] n);
        case (n)
            3'd2:    return 1;
            3'd4:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/flq_geom.sv
module flq_geom
    import flq_pkg::*;
#(
    parameter int BLK_W = 16,
    parameter int SEC_W = 32,
    parameter int WB_W  = 16
) (
    input  logic [2:0]       bank_bytes,
    input  logic [2:0]       dev_bytes,
    input  logic [BLK_W-1:0] blocks,
    input  logic [SEC_W-1:0] sector_bytes,
    output flq_geom_t        geom,
    output logic [WB_W-1:0]  wbuf_bytes
);

    localparam int LEN_W = BLK_W + SEC_W;

    logic [1:0]       nd_log2;
    logic [SEC_W-1:0] sec_per;
    logic [LEN_W-1:0] dev_len;
    logic [BLK_W-1:0] blk_m1;
    logic [7:0]       tz;
    logic [7:0]       wb_log2;

    always_comb begin
        nd_log2 = 2'd0;
        if (dev_bytes != 3'd0 && lg_bytes(bank_bytes) > lg_bytes(dev_bytes))
            nd_log2 = 2'(lg_bytes(bank_bytes) - lg_bytes(dev_bytes));
        sec_per = sector_bytes >> nd_log2;
        dev_len = LEN_W'(sec_per) * LEN_W'(blocks);
        tz = 8'(LEN_W);
        for (int i = LEN_W - 1; i >= 0; i--) begin
            if (dev_len[i]) tz = 8'(i);
        end
        blk_m1  = blocks - 1'b1;
        wb_log2 = (bank_bytes == 3'd1) ? 8'h08 : 8'h0B;

        geom.size_log2 = tz;
        geom.wbuf_log2 = wb_log2;
        geom.blk_lo    = blk_m1[7:0];
        geom.blk_hi    = 8'(blk_m1 >> 8);
        geom.sec_mid   = 8'(sec_per >> 8);
        geom.sec_hi    = 8'(sec_per >> 16);
        wbuf_bytes     = WB_W'(1) << (wb_log2 + 8'(nd_log2));
    end

endmodule

// File: rtl/flq_table.sv
module flq_table
    import flq_pkg::*;
(
    input  logic [7:0] idx,
    input  flq_geom_t  geom,
    output logic [7:0] val
);

    always_comb begin
        case (idx)
            8'h10: val = 8'h51;
            8'h11: val = 8'h52;
            8'h12: val = 8'h59;
            8'h13: val = 8'h01;
            8'h15: val = 8'h31;
            8'h1B: val = 8'h45;
            8'h1C: val = 8'h55;
            8'h1F: val = 8'h07;
            8'h20: val = 8'h07;
            8'h21: val = 8'h0A;
            8'h23: val = 8'h04;
            8'h24: val = 8'h04;
            8'h25: val = 8'h04;
            8'h27: val = geom.size_log2;
            8'h28: val = 8'h02;
            8'h2A: val = geom.wbuf_log2;
            8'h2C: val = 8'h01;
            8'h2D: val = geom.blk_lo;
            8'h2E: val = geom.blk_hi;
            8'h2F: val = geom.sec_mid;
            8'h30: val = geom.sec_hi;
            8'h31: val = 8'h50;
            8'h32: val = 8'h52;
            8'h33: val = 8'h49;
            8'h34: val = 8'h31;
            8'h35: val = 8'h30;
            8'h3F: val = 8'h01;
            default: val = 8'h00;
        endcase
    end

endmodule

// File: rtl/flq_lane.sv
module flq_lane
    import flq_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int ID_W  = 16
) (
    input  logic [OFF_W-1:0] offset,
    input  logic             ident,
    input  logic [2:0]       bank_bytes,
    input  logic [2:0]       dev_bytes,
    input  logic [2:0]       maxdev_bytes,
    input  logic [ID_W-1:0]  id_mfr,
    input  logic [ID_W-1:0]  id_dev,
    input  flq_geom_t        geom,
    output logic [RSP_W-1:0] bank_rsp
);

    logic [2:0]       mdev;
    int               sh;
    int               dv;
    logic [OFF_W-1:0] idx_full;
    logic [7:0]       tbl_byte;
    logic [RSP_W-1:0] base;
    logic             keep;

    flq_table u_tbl (
        .idx  (idx_full[7:0]),
        .geom (geom),
        .val  (tbl_byte)
    );

    always_comb begin
        mdev = (maxdev_bytes == 3'd0) ? dev_bytes : maxdev_bytes;
        dv   = int'(dev_bytes);
        sh   = lg_bytes(bank_bytes) + lg_bytes(mdev) - lg_bytes(dev_bytes);
        if (sh < 0) sh = 0;
        idx_full = offset >> sh;

        base = '0;
        keep = 1'b1;
        if (ident) begin
            case (idx_full[7:0])
                8'd0:    base = RSP_W'(id_mfr);
                8'd1:    base = RSP_W'(id_dev);
                default: keep = 1'b0;
            endcase
        end else if (idx_full >= OFF_W'(TBL_LEN)) begin
            keep = 1'b0;
        end else if (dev_bytes != mdev) begin
            if (dev_bytes == 3'd1) begin
                for (int b = 0; b < RSP_BYTES; b++) begin
                    if (b < int'(mdev)) base[8*b +: 8] = tbl_byte;
                end
            end else begin
                keep = 1'b0;
            end
        end else begin
            base = RSP_W'(tbl_byte);
        end

        bank_rsp = '0;
        if (keep) begin
            for (int j = 0; j < RSP_BYTES; j++) begin
                if (j < int'(bank_bytes)) begin
                    if (dv < int'(bank_bytes))
                        bank_rsp[8*j +: 8] = base[8*(j & (dv - 1)) +: 8];
                    else
                        bank_rsp[8*j +: 8] = base[8*j +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/flq_responder.sv
module flq_responder
    import flq_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int BLK_W = 16,
    parameter int SEC_W = 32,
    parameter int ID_W  = 16,
    parameter int WB_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_ident,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [2:0]       req_bytes,
    input  logic [2:0]       cfg_bank_bytes,
    input  logic [2:0]       cfg_dev_bytes,
    input  logic [2:0]       cfg_maxdev_bytes,
    input  logic [ID_W-1:0]  cfg_id0,
    input  logic [ID_W-1:0]  cfg_id1,
    input  logic [ID_W-1:0]  cfg_id2,
    input  logic [ID_W-1:0]  cfg_id3,
    input  logic [BLK_W-1:0] cfg_blocks,
    input  logic [SEC_W-1:0] cfg_sector_bytes,
    output logic             rsp_valid,
    output logic [RSP_W-1:0] rsp_data,
    output logic [WB_W-1:0]  wbuf_bytes
);

    localparam int LANES = RSP_BYTES;

    flq_state_e       state_q, state_d;
    flq_geom_t        geom;
    logic [RSP_W-1:0] lane_rsp [LANES];
    logic [RSP_W-1:0] bank_word;
    logic [RSP_W-1:0] legacy_word;
    logic [RSP_W-1:0] pre_word;
    logic [RSP_W-1:0] rsp_d;
    logic [7:0]       leg_idx;
    logic [7:0]       leg_byte;

    flq_geom #(
        .BLK_W (BLK_W),
        .SEC_W (SEC_W),
        .WB_W  (WB_W)
    ) u_geom (
        .bank_bytes   (cfg_bank_bytes),
        .dev_bytes    (cfg_dev_bytes),
        .blocks       (cfg_blocks),
        .sector_bytes (cfg_sector_bytes),
        .geom         (geom),
        .wbuf_bytes   (wbuf_bytes)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFF_W-1:0] lane_off;
        assign lane_off = req_offset + OFF_W'(k * int'(cfg_bank_bytes));

        flq_lane #(
            .OFF_W (OFF_W),
            .ID_W  (ID_W)
        ) u_lane (
            .offset       (lane_off),
            .ident        (req_ident),
            .bank_bytes   (cfg_bank_bytes),
            .dev_bytes    (cfg_dev_bytes),
            .maxdev_bytes (cfg_maxdev_bytes),
            .id_mfr       (cfg_id0),
            .id_dev       (cfg_id1),
            .geom         (geom),
            .bank_rsp     (lane_rsp[k])
        );
    end

    always_comb leg_idx = req_offset[7:0] >> lg_bytes(cfg_bank_bytes);

    flq_table u_leg_tbl (
        .idx  (leg_idx),
        .geom (geom),
        .val  (leg_byte)
    );

    // Response word: slice assembly, legacy selection, size masking
    always_comb begin
        int bw;
        bw = int'(cfg_bank_bytes);
        for (int j = 0; j < RSP_BYTES; j++) begin
            bank_word[8*j +: 8] = lane_rsp[j & ~(bw - 1)][8*(j & (bw - 1)) +: 8];
        end

        if (req_ident) begin
            case (leg_idx)
                8'd0:    legacy_word = (RSP_W'(cfg_id0) << 8) | RSP_W'(cfg_id1);
                8'd1:    legacy_word = (RSP_W'(cfg_id2) << 8) | RSP_W'(cfg_id3);
                default: legacy_word = '0;
            endcase
        end else if (leg_idx >= TBL_LEN) begin
            legacy_word = '0;
        end else begin
            legacy_word = RSP_W'(leg_byte);
        end

        pre_word = (cfg_dev_bytes == 3'd0) ? legacy_word : bank_word;
        for (int j = 0; j < RSP_BYTES; j++) begin
            rsp_d[8*j +: 8] = (j < int'(req_bytes)) ? pre_word[8*j +: 8] : 8'h00;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = req_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rsp_data <= '0;
        else if (req_valid) rsp_data <= rsp_d;
    end

    assign rsp_valid = (state_q == ST_VALID);

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_data)));

    // R2
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bytes == 3'd1) |=> (rsp_data[31:8] == 24'h0));

    // R7
    legacy_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ident && cfg_dev_bytes == 3'd0 &&
         cfg_bank_bytes == 3'd1 && req_offset[7:0] >= 8'd2) |=> (rsp_data == '0));

    // R11
    wbuf_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wbuf_bytes) == 1);

endmodule

// File: tb/sim_flq_responder.sv
module sim_flq_responder;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ident = 1'b0;
    logic [15:0] req_offset = '0;
    logic [2:0]  req_bytes = 3'd1;
    logic [2:0]  cfg_bank_bytes = 3'd1;
    logic [2:0]  cfg_dev_bytes = 3'd1;
    logic [2:0]  cfg_maxdev_bytes = 3'd0;
    logic [15:0] cfg_id0 = 16'h0089;
    logic [15:0] cfg_id1 = 16'h0018;
    logic [15:0] cfg_id2 = 16'h00AB;
    logic [15:0] cfg_id3 = 16'h00CD;
    logic [15:0] cfg_blocks = 16'd256;
    logic [31:0] cfg_sector_bytes = 32'h10000;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [15:0] wbuf_bytes;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_P / 2) clk = ~clk;

    flq_responder u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_ident        (req_ident),
        .req_offset       (req_offset),
        .req_bytes        (req_bytes),
        .cfg_bank_bytes   (cfg_bank_bytes),
        .cfg_dev_bytes    (cfg_dev_bytes),
        .cfg_maxdev_bytes (cfg_maxdev_bytes),
        .cfg_id0          (cfg_id0),
        .cfg_id1          (cfg_id1),
        .cfg_id2          (cfg_id2),
        .cfg_id3          (cfg_id3),
        .cfg_blocks       (cfg_blocks),
        .cfg_sector_bytes (cfg_sector_bytes),
        .rsp_valid        (rsp_valid),
        .rsp_data         (rsp_data),
        .wbuf_bytes       (wbuf_bytes)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] bank, input logic [2:0] dev, input logic [2:0] mdev,
                           input logic [15:0] blks, input logic [31:0] sect);
        @(negedge clk);
        cfg_bank_bytes   = bank;
        cfg_dev_bytes    = dev;
        cfg_maxdev_bytes = mdev;
        cfg_blocks       = blks;
        cfg_sector_bytes = sect;
    endtask

    task automatic issue(input logic idt, input logic [15:0] off, input logic [2:0] nb,
                         output logic [31:0] got);
        @(negedge clk);
        req_valid  = 1'b1;
        req_ident  = idt;
        req_offset = off;
        req_bytes  = nb;
        @(negedge clk);
        req_valid = 1'b0;
        got = rsp_data;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(rsp_valid), 32'h0);
        chk("R1 reset data", rsp_data, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_timing();
        set_cfg(3'd1, 3'd1, 3'd0, 16'd256, 32'h10000);
        @(negedge clk);
        req_valid = 1'b1; req_ident = 1'b0; req_offset = 16'h0010; req_bytes = 3'd1;
        @(negedge clk);
        chk("R1 first valid", 32'(rsp_valid), 32'h1);
        chk("R1 first data", rsp_data, 32'h51);
        req_offset = 16'h0012;
        @(negedge clk);
        chk("R1 second valid", 32'(rsp_valid), 32'h1);
        chk("R1 second data", rsp_data, 32'h59);
        req_valid = 1'b0; req_offset = 16'h0011;
        @(negedge clk);
        chk("R1 gap valid", 32'(rsp_valid), 32'h0);
        chk("R1 gap hold", rsp_data, 32'h59);
    endtask

    task automatic t_signature();
        logic [31:0] g;
        set_cfg(3'd1, 3'd1, 3'd0, 16'd256, 32'h10000);
        issue(1'b0, 16'h0010, 3'd4, g); chk("R6 R9 sig word", g, 32'h01595251);
        issue(1'b0, 16'h0031, 3'd4, g); chk("R9 ext sig", g, 32'h31495250);
        issue(1'b0, 16'h0010, 3'd2, g); chk("R2 two-byte mask", g, 32'h00005251);
        issue(1'b0, 16'h003F, 3'd1, g); chk("R9 entry 3f", g, 32'h01);
    endtask

    task automatic t_geometry_narrow();
        logic [31:0] g;
        set_cfg(3'd1, 3'd1, 3'd0, 16'd256, 32'h10000);
        issue(1'b0, 16'h0027, 3'd1, g); chk("R10 size log2", g, 32'h18);
        issue(1'b0, 16'h002A, 3'd1, g); chk("R10 wbuf log2 8-bit bank", g, 32'h08);
        issue(1'b0, 16'h002D, 3'd2, g); chk("R10 blocks-1", g, 32'h00FF);
        issue(1'b0, 16'h002F, 3'd2, g); chk("R10 sector bytes", g, 32'h0100);
        chk("R11 wbuf 1 dev", 32'(wbuf_bytes), 32'd256);
    endtask

    task automatic t_index_range();
        logic [31:0] g;
        set_cfg(3'd1, 3'd1, 3'd0, 16'd256, 32'h10000);
        issue(1'b0, 16'h0110, 3'd1, g); chk("R3 wide index zero", g, 32'h0);
        issue(1'b0, 16'h0052, 3'd1, g); chk("R3 index 52 zero", g, 32'h0);
    endtask

    task automatic t_ident_dev();
        logic [31:0] g;
        set_cfg(3'd1, 3'd1, 3'd0, 16'd256, 32'h10000);
        issue(1'b1, 16'h0000, 3'd2, g); chk("R8 R6 id pair", g, 32'h00001889);
        issue(1'b1, 16'h0002, 3'd1, g); chk("R8 id other", g, 32'h0);
        issue(1'b1, 16'h0100, 3'd1, g); chk("R8 id modulo", g, 32'h89);
    endtask

    task automatic t_wide_bank();
        logic [31:0] g;
        set_cfg(3'd2, 3'd2, 3'd0, 16'd128, 32'h20000);
        issue(1'b0, 16'h0020, 3'd4, g); chk("R6 R3 16-bit bank", g, 32'h00590051);
        issue(1'b0, 16'h005A, 3'd2, g); chk("R10 blocks-1 bank2", g, 32'h007F);
        issue(1'b0, 16'h0054, 3'd2, g); chk("R10 wbuf log2 wide", g, 32'h000B);
        chk("R11 wbuf bank2", 32'(wbuf_bytes), 32'd2048);
    endtask

    task automatic t_lane_copy();
        logic [31:0] g;
        set_cfg(3'd4, 3'd2, 3'd0, 16'd64, 32'h20000);
        issue(1'b0, 16'h0040, 3'd4, g); chk("R5 lane copy", g, 32'h00510051);
        issue(1'b0, 16'h009C, 3'd4, g); chk("R10 size two dev", g, 32'h00160016);
        issue(1'b0, 16'h00C0, 3'd4, g); chk("R10 sector per dev", g, 32'h00010001);
        issue(1'b1, 16'h0004, 3'd4, g); chk("R8 R5 dev code", g, 32'h00180018);
        chk("R11 wbuf two dev", 32'(wbuf_bytes), 32'd4096);
    endtask

    task automatic t_dev_narrow();
        logic [31:0] g;
        set_cfg(3'd2, 3'd1, 3'd2, 16'd128, 32'h20000);
        issue(1'b0, 16'h0040, 3'd4, g); chk("R4 byte fill", g, 32'h52525151);
        set_cfg(3'd4, 3'd2, 3'd4, 16'd64, 32'h20000);
        issue(1'b0, 16'h0080, 3'd4, g); chk("R4 unsupported zero", g, 32'h0);
    endtask

    task automatic t_legacy();
        logic [31:0] g;
        set_cfg(3'd2, 3'd0, 3'd0, 16'd128, 32'h20000);
        issue(1'b0, 16'h0120, 3'd4, g); chk("R7 legacy query", g, 32'h00000051);
        issue(1'b1, 16'h0000, 3'd4, g); chk("R7 legacy id0", g, 32'h00008918);
        issue(1'b1, 16'h0002, 3'd4, g); chk("R7 legacy id1", g, 32'h0000ABCD);
        issue(1'b1, 16'h0004, 3'd4, g); chk("R7 legacy other", g, 32'h0);
        issue(1'b1, 16'h0000, 3'd1, g); chk("R2 legacy mask", g, 32'h18);
        chk("R11 wbuf legacy", 32'(wbuf_bytes), 32'd2048);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_timing();
        t_signature();
        t_geometry_narrow();
        t_index_range();
        t_ident_dev();
        t_wide_bank();
        t_lane_copy();
        t_dev_narrow();
        t_legacy();
        repeat (2) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule